// File: doc/BRIEF.md
# Dual-Role SPI Controller

This block is a byte-wide serial peripheral that exchanges one 8-bit word at a time over a three-wire synchronous link. A single control bit picks the role. As the bus master it generates the serial clock from the system clock at one of eight rates and drives the outgoing data line. As a slave it follows a clock supplied from outside, and it takes part only while its active-low select input is held low. In both roles the byte moves most significant bit first, and the word received in each direction replaces the word sent.

Software reaches the block through three byte registers: control, status and data. The control register sets the role, the clock idle level, the clock phase, the clock rate and the interrupt enable. The status register holds three flags. The transfer-complete flag is set when a byte finishes. The mode-fault flag is set when another device pulls the select line low while this block is master; the block then drops back to slave and abandons the byte in flight. The write-collision flag is set when software writes the data register during a transfer; the transfer carries on and the written value is dropped. Reading the status register and then the data register clears the completion and collision flags and the received byte. Reading the status register and then writing the control register clears the mode fault.

Top module: `spiDualRole`

## Requirements
- R1: Register map: address 0 is control (bit 0 interrupt enable, bit 1 master role, bit 2 clock idle level, bit 3 clock phase, bits 6:4 rate code, bit 7 reads 0). Address 1 is status (bit 0 transfer complete, bit 1 write collision, bit 2 mode fault, others 0). Address 2 is data: a write loads the transmit byte, a read returns the received byte. After reset all three read 0, and sckOe, mosiOe, misoOe, irq and sckOut are low.
- R2: In master role, a data write while idle starts a full-duplex exchange. mosiOut presents the written byte MSB first, and the eight bits sampled on misoIn are returned by the next data read, MSB first.
- R3: In master role the period of sckOut is 2^(rate+1) system clock cycles for rate codes 0 to 7. Whenever no transfer runs, sckOut rests at the clock idle level.
- R4: With clock phase 0, data is sampled on the first (leading) clock edge of each bit and changes on the second. With clock phase 1, data changes on the leading edge and is sampled on the trailing edge. Both hold for either idle level.
- R5: Transfer complete is set after the eighth bit. When the interrupt enable is 1 it drives irq high. When the interrupt enable is 0, irq stays low.
- R6: A status read followed by a data read clears transfer complete and write collision, and the received byte then reads 0. A data read without a preceding status read leaves the flag and the byte unchanged.
- R7: A data write during a transfer sets write collision. The transfer in progress completes with the original transmit byte and the correct received byte, and the written value is discarded.
- R8: While in master role, a low ssN sets mode fault, clears the master bit, drops sckOe and mosiOe, aborts the transfer without setting transfer complete, and raises irq if enabled. A status read followed by a control write clears mode fault.
- R9: In slave role, while ssN is low, the block samples mosiIn and drives misoOut MSB first on the external clock in every phase and polarity. The received byte is readable after the eighth bit. With phase 0, the first output bit is on misoOut after ssN falls and before the first clock edge.
- R10: In slave role with ssN high, misoOe is low and clock edges on sckIn are ignored: no bits are counted and transfer complete stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (for read side effects) |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for regAddr |
| irq | output | 1 | Interrupt request |
| sckIn | input | 1 | Serial clock from an external master |
| sckOut | output | 1 | Generated serial clock |
| sckOe | output | 1 | Enable for the sckOut driver |
| mosiIn | input | 1 | Data from an external master |
| mosiOut | output | 1 | Data to slaves |
| mosiOe | output | 1 | Enable for the mosiOut driver |
| misoIn | input | 1 | Data from a slave |
| misoOut | output | 1 | Data to an external master |
| misoOe | output | 1 | Enable for the misoOut driver |
| ssN | input | 1 | Active-low slave select |

## Verification
The properties assume that sckIn and ssN come from a source slower than the system clock, with each level held long enough to pass the two-stage synchronizer. They also assume the control register is not rewritten while a master transfer runs. The stimulus holds every external clock level and every select change for eight system cycles and keeps mosiIn steady between edges. It writes the control register only between bytes. It pulls ssN low in master role only for the mode-fault case, so the fault and collision properties see the patterns they describe and nothing else.

// File: rtl/spiDualRolePkg.sv
`timescale 1ns/1ps
package spiDualRolePkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  localparam int CB_IRQEN  = 0;
  localparam int CB_MASTER = 1;
  localparam int CB_CPOL   = 2;
  localparam int CB_CPHA   = 3;
  localparam int CB_RATE   = 4;

  localparam int SB_DONE = 0;
  localparam int SB_WCOL = 1;
  localparam int SB_MODF = 2;

  typedef struct packed {
    logic load;
    logic lead;
    logic trail;
    logic capture;
    logic clearRx;
  } spiStrobe_t;

  typedef struct packed {
    logic isMaster;
    logic cpol;
    logic cpha;
    logic irqEn;
    logic busy;
    logic ssActive;
    logic done;
    logic wcol;
    logic modf;
    logic dataWr;
  } ctlView_t;
endpackage

// File: rtl/spiDualRoleData.sv
`timescale 1ns/1ps
module spiDualRoleData
  import spiDualRolePkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobe_t        stb,
  input  logic              cpha,
  input  logic              dinBit,
  input  logic [DATA_W-1:0] wrData,
  output logic              doutBit,
  output logic [DATA_W-1:0] rxByte
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] shNext;
  logic              latchBit;
  logic              outBit;

  // phase 1 shifts the live input in on the trailing edge; phase 0 uses the bit held since the leading edge
  assign shNext  = cpha ? {shReg[MSB-1:0], dinBit} : {shReg[MSB-1:0], latchBit};
  assign doutBit = cpha ? outBit : shReg[MSB];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      latchBit <= 1'b0;
      outBit   <= 1'b0;
      rxByte   <= '0;
    end else begin
      if (stb.load)       shReg <= wrData;
      else if (stb.trail) shReg <= shNext;

      if (stb.lead) begin
        if (cpha) outBit   <= shReg[MSB];
        else      latchBit <= dinBit;
      end

      if (stb.capture)      rxByte <= shNext;
      else if (stb.clearRx) rxByte <= '0;
    end
  end
endmodule

// File: rtl/spiDualRoleCtrl.sv
`timescale 1ns/1ps
module spiDualRoleCtrl
  import spiDualRolePkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RATE_W = 3,
  parameter int CTRL_W = 4 + RATE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [CTRL_W-1:0] ctrlWrBits,
  output logic [DATA_W-1:0] regRdData,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              sckIn,
  input  logic              ssN,
  output logic              sckOut,
  output logic              sckOe,
  output logic              mosiOe,
  output logic              misoOe,
  output logic              irq,
  output spiStrobe_t        stb,
  output ctlView_t          view
);
  localparam int HALF_W = (1 << RATE_W) - 1;
  localparam int CNT_W  = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic              irqEn, isMaster, cpol, cpha;
  logic [RATE_W-1:0] rate;
  logic              doneF, wcolF, modfF, statusSeen;
  logic              busy, phase;
  logic [HALF_W-1:0] halfCnt, halfLim;
  logic [CNT_W-1:0]  bitCnt;
  logic              sckS1, sckS2, sckS3, ssS1, ssS2;

  logic wrCtrl, wrData, rdStat, rdData;
  logic ssActive, sckEdge, modeFaultNow, xferBusy, mTick, startM, lastBit;

  assign wrCtrl = regWrEn && (regAddr == ADDR_CTRL);
  assign wrData = regWrEn && (regAddr == ADDR_DATA);
  assign rdStat = regRdEn && (regAddr == ADDR_STAT);
  assign rdData = regRdEn && (regAddr == ADDR_DATA);

  assign ssActive     = !ssS2;
  assign sckEdge      = sckS2 ^ sckS3;
  assign modeFaultNow = isMaster && ssActive;
  assign xferBusy     = isMaster ? busy : ssActive;
  assign halfLim      = HALF_W'((32'd1 << rate) - 32'd1);
  assign mTick        = busy && (halfCnt == halfLim) && !modeFaultNow;
  assign lastBit      = (bitCnt == LAST_BIT);

  always_comb begin
    stb = '0;
    stb.load = wrData && !xferBusy;
    if (isMaster) begin
      stb.lead  = mTick && !phase;
      stb.trail = mTick && phase;
    end else begin
      stb.lead  = ssActive && sckEdge && (sckS2 != cpol);
      stb.trail = ssActive && sckEdge && (sckS2 == cpol);
    end
    stb.capture = stb.trail && lastBit;
    stb.clearRx = rdData && statusSeen;
  end

  assign startM = stb.load && isMaster && !modeFaultNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckS1 <= 1'b0; sckS2 <= 1'b0; sckS3 <= 1'b0;
      ssS1  <= 1'b1; ssS2  <= 1'b1;
    end else begin
      sckS1 <= sckIn; sckS2 <= sckS1; sckS3 <= sckS2;
      ssS1  <= ssN;   ssS2  <= ssS1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEn <= 1'b0; isMaster <= 1'b0; cpol <= 1'b0; cpha <= 1'b0; rate <= '0;
      busy <= 1'b0; phase <= 1'b0; halfCnt <= '0; bitCnt <= '0;
    end else begin
      if (wrCtrl) begin
        irqEn    <= ctrlWrBits[CB_IRQEN];
        isMaster <= ctrlWrBits[CB_MASTER];
        cpol     <= ctrlWrBits[CB_CPOL];
        cpha     <= ctrlWrBits[CB_CPHA];
        rate     <= ctrlWrBits[CB_RATE +: RATE_W];
      end

      if (startM) begin
        busy    <= 1'b1;
        halfCnt <= '0;
      end else if (busy) begin
        if (halfCnt == halfLim) begin
          halfCnt <= '0;
          phase   <= ~phase;
        end else begin
          halfCnt <= halfCnt + 1'b1;
        end
        if (stb.capture) busy <= 1'b0;
      end

      if (startM || (!isMaster && !ssActive)) bitCnt <= '0;
      else if (stb.trail)                     bitCnt <= bitCnt + 1'b1;

      if (!isMaster) begin
        busy <= 1'b0; phase <= 1'b0; halfCnt <= '0;
      end

      if (modeFaultNow) begin
        isMaster <= 1'b0; busy <= 1'b0; phase <= 1'b0; halfCnt <= '0; bitCnt <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneF <= 1'b0; wcolF <= 1'b0; modfF <= 1'b0; statusSeen <= 1'b0;
    end else begin
      if (rdData && statusSeen) begin
        doneF <= 1'b0;
        wcolF <= 1'b0;
      end
      if (wrCtrl && statusSeen) modfF <= 1'b0;
      if (stb.capture)          doneF <= 1'b1;
      if (wrData && xferBusy)   wcolF <= 1'b1;
      if (modeFaultNow)         modfF <= 1'b1;

      if (rdStat)                 statusSeen <= 1'b1;
      else if (rdData || wrCtrl)  statusSeen <= 1'b0;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CTRL: begin
        regRdData[CB_IRQEN]            = irqEn;
        regRdData[CB_MASTER]           = isMaster;
        regRdData[CB_CPOL]             = cpol;
        regRdData[CB_CPHA]             = cpha;
        regRdData[CB_RATE +: RATE_W]   = rate;
      end
      ADDR_STAT: begin
        regRdData[SB_DONE] = doneF;
        regRdData[SB_WCOL] = wcolF;
        regRdData[SB_MODF] = modfF;
      end
      ADDR_DATA: regRdData = rxByte;
      default:   regRdData = '0;
    endcase
  end

  assign sckOut = cpol ^ phase;
  assign sckOe  = isMaster;
  assign mosiOe = isMaster;
  assign misoOe = !isMaster && ssActive;
  assign irq    = irqEn && (doneF || modfF);

  always_comb begin
    view.isMaster = isMaster;
    view.cpol     = cpol;
    view.cpha     = cpha;
    view.irqEn    = irqEn;
    view.busy     = xferBusy;
    view.ssActive = ssActive;
    view.done     = doneF;
    view.wcol     = wcolF;
    view.modf     = modfF;
    view.dataWr   = wrData;
  end
endmodule

// File: rtl/spiDualRole.sv
`timescale 1ns/1ps
module spiDualRole
  import spiDualRolePkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irq,
  input  logic              sckIn,
  output logic              sckOut,
  output logic              sckOe,
  input  logic              mosiIn,
  output logic              mosiOut,
  output logic              mosiOe,
  input  logic              misoIn,
  output logic              misoOut,
  output logic              misoOe,
  input  logic              ssN
);
  localparam int CTRL_W = 4 + RATE_W;

  spiStrobe_t        stb;
  ctlView_t          view;
  logic              dinBit;
  logic              doutBit;
  logic [DATA_W-1:0] rxByte;

  assign dinBit  = view.isMaster ? misoIn : mosiIn;
  assign mosiOut = doutBit;
  assign misoOut = doutBit;

  spiDualRoleCtrl #(.DATA_W(DATA_W), .RATE_W(RATE_W), .CTRL_W(CTRL_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .ctrlWrBits(regWrData[CTRL_W-1:0]), .regRdData(regRdData), .rxByte(rxByte),
    .sckIn(sckIn), .ssN(ssN),
    .sckOut(sckOut), .sckOe(sckOe), .mosiOe(mosiOe), .misoOe(misoOe), .irq(irq),
    .stb(stb), .view(view)
  );

  spiDualRoleData #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .cpha(view.cpha),
    .dinBit(dinBit), .wrData(regWrData), .doutBit(doutBit), .rxByte(rxByte)
  );
endmodule

// File: rtl/spiDualRoleChk.sv
`timescale 1ns/1ps
module spiDualRoleChk
  import spiDualRolePkg::*;
(
  input logic     clk,
  input logic     rstN,
  input logic     sckOut,
  input logic     sckOe,
  input logic     misoOe,
  input logic     irq,
  input ctlView_t view
);
  a_r8_fault_drops_master: assert property (@(posedge clk) disable iff (!rstN)
    (view.isMaster && view.ssActive) |=> (!view.isMaster && view.modf && !sckOe));

  a_r7_collision_flagged: assert property (@(posedge clk) disable iff (!rstN)
    (view.dataWr && view.busy) |=> view.wcol);

  a_r3_clock_rests_idle: assert property (@(posedge clk) disable iff (!rstN)
    (sckOe && !view.busy) |-> (sckOut == view.cpol));

  a_r10_miso_released: assert property (@(posedge clk) disable iff (!rstN)
    !view.ssActive |-> !misoOe);

  a_r2_done_ends_master_run: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(view.done) && view.isMaster) |-> !view.busy);

  a_r5_done_raises_irq: assert property (@(posedge clk) disable iff (!rstN)
    (view.irqEn && $rose(view.done)) |-> irq);
endmodule

bind spiDualRole spiDualRoleChk uChk (
  .clk(clk), .rstN(rstN), .sckOut(sckOut), .sckOe(sckOe),
  .misoOe(misoOe), .irq(irq), .view(view)
);

// File: tb/spiDualRole_test.sv
`timescale 1ns/1ps
module spiDualRole_test;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam int H = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       irq, sckOut, sckOe, mosiOut, mosiOe, misoOut, misoOe;
  logic       sckIn = 1'b0, mosiIn = 1'b0, misoIn = 1'b0, ssN = 1'b1;

  spiDualRole uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irq(irq),
    .sckIn(sckIn), .sckOut(sckOut), .sckOe(sckOe),
    .mosiIn(mosiIn), .mosiOut(mosiOut), .mosiOe(mosiOe),
    .misoIn(misoIn), .misoOut(misoOut), .misoOe(misoOe), .ssN(ssN)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bench-side slave model for master-role tests
  logic       monOn = 1'b0, mCpol = 1'b0, mCpha = 1'b0, prevSck = 1'b0, isLead;
  logic [7:0] pat = 8'd0, mCap = 8'd0;
  int         idx = 0, mCnt = 0, lastRise = -1, period = 0;

  always @(negedge clk) begin
    if (monOn && sckOe && (sckOut !== prevSck)) begin
      isLead = (sckOut != mCpol);
      if (isLead != mCpha) begin
        mCap = {mCap[6:0], mosiOut};
        mCnt++;
      end
      if (!mCpha && !isLead) begin
        idx++;
        if (idx < 8) misoIn = pat[7-idx];
      end
      if (mCpha && isLead) begin
        if (idx < 8) misoIn = pat[7-idx];
        idx++;
      end
      if (sckOut) begin
        if (lastRise >= 0) period = cyc - lastRise;
        lastRise = cyc;
      end
    end
    prevSck = sckOut;
  end

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk); regRdEn = 1'b0;
  endtask

  task automatic waitIrq(input int lim, input string tag);
    int n = 0;
    while (irq !== 1'b1 && n < lim) begin @(negedge clk); n++; end
    check(tag, 32'(irq), 32'd1);
  endtask

  task automatic tReset();
    logic [7:0] v;
    check("R1 sckOe", 32'(sckOe), 32'd0);
    check("R1 mosiOe", 32'(mosiOe), 32'd0);
    check("R1 misoOe", 32'(misoOe), 32'd0);
    check("R1 irq", 32'(irq), 32'd0);
    check("R1 sckOut", 32'(sckOut), 32'd0);
    regRead(A_CTRL, v); check("R1 ctrl", 32'(v), 32'd0);
    regRead(A_STAT, v); check("R1 status", 32'(v), 32'd0);
    regRead(A_DATA, v); check("R1 data", 32'(v), 32'd0);
  endtask

  task automatic tMaster(input logic cpolV, input logic cphaV, input logic [2:0] rateV,
                         input logic [7:0] tx, input logic [7:0] sl);
    logic [7:0] v;
    regWrite(A_CTRL, {1'b0, rateV, cphaV, cpolV, 1'b1, 1'b1});
    @(negedge clk);
    mCpol = cpolV; mCpha = cphaV; pat = sl; idx = 0; mCap = 8'd0; mCnt = 0;
    lastRise = -1; period = 0; misoIn = cphaV ? 1'b0 : sl[7];
    prevSck = sckOut; monOn = 1'b1;
    check("R3 idle before", 32'(sckOut), 32'(cpolV));
    regWrite(A_DATA, tx);
    waitIrq(5000, "R5 irq on done");
    repeat (2) @(negedge clk);
    monOn = 1'b0;
    check("R2 R4 mosi byte", 32'(mCap), 32'(tx));
    check("R4 sample edges", mCnt, 8);
    check("R3 sck period", period, 2 << rateV);
    check("R3 idle after", 32'(sckOut), 32'(cpolV));
    regRead(A_DATA, v); check("R2 R4 miso byte", 32'(v), 32'(sl));
    regRead(A_STAT, v); check("R6 done kept", 32'(v), 32'd1);
    regRead(A_DATA, v); check("R6 byte kept", 32'(v), 32'(sl));
    regRead(A_STAT, v); check("R6 done cleared", 32'(v), 32'd0);
    regRead(A_DATA, v); check("R6 byte cleared", 32'(v), 32'd0);
    check("R5 irq cleared", 32'(irq), 32'd0);
  endtask

  task automatic tNoIrq();
    logic [7:0] v;
    regWrite(A_CTRL, {1'b0, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0});
    misoIn = 1'b1;
    regWrite(A_DATA, 8'h81);
    repeat (16 * 2 + 20) @(negedge clk);
    check("R5 irq masked", 32'(irq), 32'd0);
    regRead(A_STAT, v); check("R5 done without irq", 32'(v), 32'd1);
    regRead(A_DATA, v); check("R5 rx all ones", 32'(v), 32'hFF);
  endtask

  task automatic tCollision();
    logic [7:0] v;
    regWrite(A_CTRL, {1'b0, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1});
    @(negedge clk);
    mCpol = 1'b0; mCpha = 1'b0; pat = 8'h5A; idx = 0; mCap = 8'd0; mCnt = 0;
    misoIn = 1'b0; prevSck = sckOut; monOn = 1'b1;
    regWrite(A_DATA, 8'hA5);
    repeat (40) @(negedge clk);
    regWrite(A_DATA, 8'h3C);
    waitIrq(5000, "R7 transfer completes");
    repeat (2) @(negedge clk);
    monOn = 1'b0;
    check("R7 tx undisturbed", 32'(mCap), 32'hA5);
    regRead(A_STAT, v); check("R7 wcol and done", 32'(v), 32'd3);
    regRead(A_DATA, v); check("R7 rx undisturbed", 32'(v), 32'h5A);
    regRead(A_STAT, v); check("R7 wcol cleared", 32'(v), 32'd0);
  endtask

  task automatic tModeFault();
    logic [7:0] v;
    regWrite(A_CTRL, {1'b0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b1});
    misoIn = 1'b0;
    regWrite(A_DATA, 8'hC3);
    repeat (20) @(negedge clk);
    ssN = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 sckOe dropped", 32'(sckOe), 32'd0);
    check("R8 mosiOe dropped", 32'(mosiOe), 32'd0);
    check("R8 irq raised", 32'(irq), 32'd1);
    regRead(A_CTRL, v); check("R8 master bit cleared", 32'(v[1]), 32'd0);
    regRead(A_STAT, v); check("R8 modf only", 32'(v), 32'd4);
    ssN = 1'b1;
    repeat (4) @(negedge clk);
    regRead(A_STAT, v);
    regWrite(A_CTRL, 8'h00);
    regRead(A_STAT, v); check("R8 modf cleared", 32'(v), 32'd0);
    check("R8 irq cleared", 32'(irq), 32'd0);
  endtask

  task automatic tSlave(input logic cpolV, input logic cphaV, input logic [7:0] mo, input logic [7:0] pre);
    logic [7:0] v;
    logic [7:0] cap = 8'd0;
    regWrite(A_CTRL, {1'b0, 3'd0, cphaV, cpolV, 1'b0, 1'b1});
    sckIn = cpolV; ssN = 1'b1;
    regWrite(A_DATA, pre);
    repeat (4) @(negedge clk);
    ssN = 1'b0;
    if (!cphaV) mosiIn = mo[7];
    repeat (H) @(negedge clk);
    check("R10 misoOe with select", 32'(misoOe), 32'd1);
    if (!cphaV) check("R9 early first bit", 32'(misoOut), 32'(pre[7]));
    for (int i = 0; i < 8; i++) begin
      if (!cphaV) begin
        cap = {cap[6:0], misoOut};
        sckIn = ~sckIn;
        repeat (H) @(negedge clk);
        sckIn = ~sckIn;
        if (i < 7) mosiIn = mo[6-i];
        repeat (H) @(negedge clk);
      end else begin
        sckIn = ~sckIn;
        mosiIn = mo[7-i];
        repeat (H) @(negedge clk);
        cap = {cap[6:0], misoOut};
        sckIn = ~sckIn;
        repeat (H) @(negedge clk);
      end
    end
    check("R9 miso byte", 32'(cap), 32'(pre));
    check("R9 irq on done", 32'(irq), 32'd1);
    ssN = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 misoOe released", 32'(misoOe), 32'd0);
    regRead(A_STAT, v); check("R9 done", 32'(v), 32'd1);
    regRead(A_DATA, v); check("R9 mosi byte", 32'(v), 32'(mo));
  endtask

  task automatic tSlaveIgnore();
    logic [7:0] v;
    int oeSeen = 0;
    regWrite(A_CTRL, {1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1});
    ssN = 1'b1; sckIn = 1'b0;
    for (int i = 0; i < 16; i++) begin
      sckIn = ~sckIn;
      mosiIn = i[0];
      repeat (H) @(negedge clk);
      if (misoOe !== 1'b0) oeSeen++;
    end
    check("R10 misoOe stays low", oeSeen, 0);
    regRead(A_STAT, v); check("R10 edges ignored", 32'(v), 32'd0);
    check("R10 no irq", 32'(irq), 32'd0);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    tReset();
    tMaster(1'b0, 1'b0, 3'd0, 8'hA5, 8'h3C);
    tMaster(1'b0, 1'b1, 3'd2, 8'h96, 8'h71);
    tMaster(1'b1, 1'b0, 3'd7, 8'h01, 8'h80);
    tMaster(1'b1, 1'b1, 3'd1, 8'hE4, 8'h2B);
    tNoIrq();
    tCollision();
    tModeFault();
    tSlave(1'b0, 1'b0, 8'hB2, 8'h4D);
    tSlave(1'b0, 1'b1, 8'h1F, 8'hE8);
    tSlave(1'b1, 1'b0, 8'h69, 8'hA3);
    tSlave(1'b1, 1'b1, 8'hC5, 8'h5C);
    tSlaveIgnore();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule